// File: doc/BRIEF.md
# Next-PC and Exception Sequencer

This block decides, every cycle, which address the core fetches next. It receives the address of the instruction now in execution, the full instruction word, the two register operands read for it, and three exception request lines. From these it picks one of four things: the sequential successor, a conditional branch target, a direct jump target spliced into the current address region, or a register-held jump target. For the two call forms it also supplies the return address and the register index that should receive it.

When any exception request is raised, the block overrides every other choice and redirects to a fixed trap vector. On the next clock edge it records the faulting address and a cause code in two internal registers. The core can read these back through a small coprocessor-style read port that takes a register selector. The next-PC path is purely combinational. The only state in the block is the pair of trap registers.

Top module: `pc_sequencer`

## Requirements
- R1: For any instruction that is not a branch or jump, and with no exception request, next_pc_o equals pc_i + 4.
- R2: For opcode 4 (branch if operands equal) and opcode 5 (branch if operands differ), a taken branch gives pc_i + 4 + (sign-extended instr[15:0] shifted left by 2). A branch that is not taken gives pc_i + 4.
- R3: Opcode 6 branches when rs_val_i is less than or equal to zero. Opcode 7 branches when rs_val_i is greater than zero. Opcode 1 branches when rs_val_i is below zero, but only if instr[20:16] is 0; with any other instr[20:16] it behaves as R1. All three comparisons are signed, and the target is formed as in R2.
- R4: Opcodes 2 and 3 give next_pc_o = {pc_i[31:28], instr[25:0], 2'b00}.
- R5: With opcode 0, function field instr[5:0] = 8 or 9 gives next_pc_o = rs_val_i.
- R6: Opcode 3 raises link_we_o with link_idx_o = 31. Opcode 0 with function 9 raises link_we_o with link_idx_o = instr[15:11]. In both cases link_val_o = pc_i + 4. For every other instruction, link_we_o is low.
- R7: While any exception request is high, next_pc_o equals TRAP_VECTOR (default 0x80000180), whatever the instruction. At the following clock edge the saved-address register takes pc_i.
- R8: At an exception edge the cause register is loaded with 10 for illegal opcode, 12 for overflow and 4 for bad memory address. When several requests are high together, the priority is illegal opcode, then overflow, then memory.
- R9: While any exception request is high, link_we_o stays low.
- R10: cp0_sel_i = 14 reads the saved address and cp0_sel_i = 13 reads the cause, zero-extended to 32 bits. Any other selector reads 0. Both registers are 0 after reset, and both hold their value on every edge without an exception request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_i | input | 32 | Address of the instruction in execution |
| instr_i | input | 32 | Instruction word in execution |
| rs_val_i | input | 32 | First register operand |
| rt_val_i | input | 32 | Second register operand |
| exc_illegal_i | input | 1 | Illegal-opcode exception request |
| exc_ovf_i | input | 1 | Arithmetic-overflow exception request |
| exc_mem_i | input | 1 | Bad-memory-address exception request |
| cp0_sel_i | input | 5 | Trap register read selector |
| next_pc_o | output | 32 | Address to fetch next |
| link_we_o | output | 1 | Return-address write enable |
| link_idx_o | output | 5 | Return-address destination register |
| link_val_o | output | 32 | Return address |
| cp0_rdata_o | output | 32 | Trap register read data |

## Verification
Two functions can land in the same cycle. One is a call (opcode 3, or the register call form) that also carries an exception request; the other is a taken branch or jump with any request raised. The bench provokes both cases directly and also through random stimulus that raises requests about one cycle in six. It judges them against its reference model: next_pc_o must be the trap vector, link_we_o must be low, and the saved address read back on the following cycle must be the call's own pc_i. Requests arriving together in various combinations test the cause priority, which is judged through cause reads on the next cycle.

// File: rtl/pcseq_pkg.sv
// Shared constants, flow kinds and field helpers for the next-PC sequencer.
// Assumes a 32-bit address and instruction word.
package pcseq_pkg;
    localparam int XLEN     = 32;
    localparam int OPC_W    = 6;
    localparam int RIDX_W   = 5;
    localparam int CODE_W   = 4;
    localparam int IMM_W    = 16;
    localparam int TGT_W    = 26;
    localparam int REGION_W = XLEN - TGT_W - 2;

    localparam logic [OPC_W-1:0] OPC_REGOP = 6'd0;
    localparam logic [OPC_W-1:0] OPC_ZCMP  = 6'd1;
    localparam logic [OPC_W-1:0] OPC_JMP   = 6'd2;
    localparam logic [OPC_W-1:0] OPC_CALL  = 6'd3;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'd4;
    localparam logic [OPC_W-1:0] OPC_BNE   = 6'd5;
    localparam logic [OPC_W-1:0] OPC_BLE0  = 6'd6;
    localparam logic [OPC_W-1:0] OPC_BGT0  = 6'd7;
    localparam logic [5:0]       FN_RJMP   = 6'd8;
    localparam logic [5:0]       FN_RCALL  = 6'd9;

    localparam logic [CODE_W-1:0] CODE_ILLEGAL = 4'd10;
    localparam logic [CODE_W-1:0] CODE_OVF     = 4'd12;
    localparam logic [CODE_W-1:0] CODE_MEM     = 4'd4;

    localparam logic [RIDX_W-1:0] SEL_CAUSE = 5'd13;
    localparam logic [RIDX_W-1:0] SEL_EPC   = 5'd14;

    typedef enum logic [3:0] {
        FLOW_SEQ, FLOW_BEQ, FLOW_BNE, FLOW_BLE0, FLOW_BGT0,
        FLOW_BLT0, FLOW_JMP, FLOW_CALL, FLOW_RJMP, FLOW_RCALL
    } flow_e;
endpackage

// File: rtl/pcseq_decode.sv
// Classifies the instruction into a control-flow kind.
// Assumes only the opcode, the rt field and the function field are needed.
module pcseq_decode
    import pcseq_pkg::*;
(
    input  logic [OPC_W-1:0]  opc_i,
    input  logic [RIDX_W-1:0] rt_fld_i,
    input  logic [5:0]        funct_i,
    output flow_e             flow_o
);
    // Map opcode / sub-fields to a flow kind; everything else is sequential.
    always_comb begin
        flow_o = FLOW_SEQ;
        case (opc_i)
            OPC_REGOP: begin
                if (funct_i == FN_RJMP)       flow_o = FLOW_RJMP;
                else if (funct_i == FN_RCALL) flow_o = FLOW_RCALL;
            end
            OPC_ZCMP:  if (rt_fld_i == '0) flow_o = FLOW_BLT0;
            OPC_JMP:   flow_o = FLOW_JMP;
            OPC_CALL:  flow_o = FLOW_CALL;
            OPC_BEQ:   flow_o = FLOW_BEQ;
            OPC_BNE:   flow_o = FLOW_BNE;
            OPC_BLE0:  flow_o = FLOW_BLE0;
            OPC_BGT0:  flow_o = FLOW_BGT0;
            default:   flow_o = FLOW_SEQ;
        endcase
    end
endmodule

// File: rtl/pcseq_target.sv
// Computes the non-trap next address and the sequential successor.
// Assumes the flow kind is already decoded; branch offsets are word offsets.
module pcseq_target
    import pcseq_pkg::*;
(
    input  logic [XLEN-1:0]  pc_i,
    input  logic [TGT_W-1:0] low_fld_i,
    input  logic [XLEN-1:0]  rs_val_i,
    input  logic [XLEN-1:0]  rt_val_i,
    input  flow_e            flow_i,
    output logic [XLEN-1:0]  seq_pc_o,
    output logic [XLEN-1:0]  flow_pc_o
);
    logic [IMM_W-1:0] imm;
    logic [XLEN-1:0]  br_tgt;
    logic [XLEN-1:0]  jmp_tgt;
    logic             rs_neg;
    logic             rs_zero;
    logic             ops_eq;
    logic             taken;

    // Candidate targets and signed comparison flags.
    always_comb begin
        imm      = low_fld_i[IMM_W-1:0];
        seq_pc_o = pc_i + XLEN'(4);
        br_tgt   = seq_pc_o + {{(XLEN-IMM_W-2){imm[IMM_W-1]}}, imm, 2'b00};
        jmp_tgt  = {pc_i[XLEN-1 -: REGION_W], low_fld_i, 2'b00};
        rs_neg   = rs_val_i[XLEN-1];
        rs_zero  = (rs_val_i == '0);
        ops_eq   = (rs_val_i == rt_val_i);
    end

    // Branch resolution per flow kind.
    always_comb begin
        case (flow_i)
            FLOW_BEQ:  taken = ops_eq;
            FLOW_BNE:  taken = !ops_eq;
            FLOW_BLE0: taken = rs_neg || rs_zero;
            FLOW_BGT0: taken = !rs_neg && !rs_zero;
            FLOW_BLT0: taken = rs_neg;
            default:   taken = 1'b0;
        endcase
    end

    // Select the final non-trap address.
    always_comb begin
        case (flow_i)
            FLOW_JMP, FLOW_CALL:   flow_pc_o = jmp_tgt;
            FLOW_RJMP, FLOW_RCALL: flow_pc_o = rs_val_i;
            default:               flow_pc_o = taken ? br_tgt : seq_pc_o;
        endcase
    end
endmodule

// File: rtl/pcseq_trap.sv
// Holds the saved faulting address and cause code and serves reads of both.
// Assumes request lines are level signals valid for the cycle they are high.
module pcseq_trap
    import pcseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XLEN-1:0]   pc_i,
    input  logic              exc_illegal_i,
    input  logic              exc_ovf_i,
    input  logic              exc_mem_i,
    input  logic [RIDX_W-1:0] cp0_sel_i,
    output logic              trap_o,
    output logic [XLEN-1:0]   epc_o,
    output logic [CODE_W-1:0] cause_o,
    output logic [XLEN-1:0]   cp0_rdata_o
);
    logic [CODE_W-1:0] code_nxt;

    // Fixed-priority cause encoding.
    always_comb begin
        trap_o = exc_illegal_i || exc_ovf_i || exc_mem_i;
        if (exc_illegal_i)  code_nxt = CODE_ILLEGAL;
        else if (exc_ovf_i) code_nxt = CODE_OVF;
        else                code_nxt = CODE_MEM;
    end

    // Capture address and cause on a trap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc_o   <= '0;
            cause_o <= '0;
        end else if (trap_o) begin
            epc_o   <= pc_i;
            cause_o <= code_nxt;
        end
    end

    // Register read mux.
    always_comb begin
        case (cp0_sel_i)
            SEL_EPC:   cp0_rdata_o = epc_o;
            SEL_CAUSE: cp0_rdata_o = {{(XLEN-CODE_W){1'b0}}, cause_o};
            default:   cp0_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/pc_sequencer.sv
// Top of the next-PC and exception sequencer: combines flow decode,
// target selection, trap override and return-address generation.
// Assumes the caller registers next_pc_o into its own PC.
module pc_sequencer
    import pcseq_pkg::*;
#(
    parameter logic [31:0] TRAP_VECTOR = 32'h8000_0180,
    parameter int unsigned RETURN_REG  = 31
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [XLEN-1:0]   instr_i,
    input  logic [XLEN-1:0]   rs_val_i,
    input  logic [XLEN-1:0]   rt_val_i,
    input  logic              exc_illegal_i,
    input  logic              exc_ovf_i,
    input  logic              exc_mem_i,
    input  logic [RIDX_W-1:0] cp0_sel_i,
    output logic [XLEN-1:0]   next_pc_o,
    output logic              link_we_o,
    output logic [RIDX_W-1:0] link_idx_o,
    output logic [XLEN-1:0]   link_val_o,
    output logic [XLEN-1:0]   cp0_rdata_o
);
    flow_e             flow;
    logic [XLEN-1:0]   seq_pc;
    logic [XLEN-1:0]   flow_pc;
    logic              trap;
    logic [XLEN-1:0]   epc_w;
    logic [CODE_W-1:0] cause_w;

    pcseq_decode u_decode (
        .opc_i    (instr_i[XLEN-1 -: OPC_W]),
        .rt_fld_i (instr_i[20:16]),
        .funct_i  (instr_i[5:0]),
        .flow_o   (flow)
    );

    pcseq_target u_target (
        .pc_i      (pc_i),
        .low_fld_i (instr_i[TGT_W-1:0]),
        .rs_val_i  (rs_val_i),
        .rt_val_i  (rt_val_i),
        .flow_i    (flow),
        .seq_pc_o  (seq_pc),
        .flow_pc_o (flow_pc)
    );

    pcseq_trap u_trap (
        .clk           (clk),
        .rst_n         (rst_n),
        .pc_i          (pc_i),
        .exc_illegal_i (exc_illegal_i),
        .exc_ovf_i     (exc_ovf_i),
        .exc_mem_i     (exc_mem_i),
        .cp0_sel_i     (cp0_sel_i),
        .trap_o        (trap),
        .epc_o         (epc_w),
        .cause_o       (cause_w),
        .cp0_rdata_o   (cp0_rdata_o)
    );

    // Trap vector overrides every other next-address choice.
    always_comb begin
        next_pc_o = trap ? TRAP_VECTOR : flow_pc;
    end

    // Return-address write for call forms, suppressed by a trap.
    always_comb begin
        link_val_o = seq_pc;
        link_we_o  = !trap && (flow == FLOW_CALL || flow == FLOW_RCALL);
        link_idx_o = (flow == FLOW_CALL) ? RIDX_W'(RETURN_REG) : instr_i[15:11];
    end
endmodule

// File: rtl/pcseq_checker.sv
// Property checker for pc_sequencer, attached by bind below.
module pcseq_checker
    import pcseq_pkg::*;
#(
    parameter logic [31:0] TRAP_VECTOR = 32'h8000_0180
)(
    input logic              clk,
    input logic              rst_n,
    input logic [XLEN-1:0]   pc_i,
    input logic [OPC_W-1:0]  opc_i,
    input logic              exc_illegal_i,
    input logic              exc_ovf_i,
    input logic              exc_mem_i,
    input logic [XLEN-1:0]   next_pc_o,
    input logic              link_we_o,
    input logic [RIDX_W-1:0] link_idx_o,
    input logic [XLEN-1:0]   epc_w,
    input logic [CODE_W-1:0] cause_w
);
    logic exc_any;
    always_comb exc_any = exc_illegal_i || exc_ovf_i || exc_mem_i;

    p_vector_r7: assert property (@(posedge clk) disable iff (!rst_n)
        exc_any |-> next_pc_o == TRAP_VECTOR);

    p_epc_save_r7: assert property (@(posedge clk) disable iff (!rst_n)
        exc_any |=> epc_w == $past(pc_i));

    p_cause_illegal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        exc_illegal_i |=> cause_w == 4'd10);

    p_cause_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_illegal_i && exc_ovf_i) |=> cause_w == 4'd12);

    p_no_link_r9: assert property (@(posedge clk) disable iff (!rst_n)
        exc_any |-> !link_we_o);

    p_hold_regs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_any |=> $stable(epc_w) && $stable(cause_w));

    p_jump_region_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_any && opc_i == 6'd2) |->
            (next_pc_o[1:0] == 2'b00 && next_pc_o[31:28] == pc_i[31:28]));

    p_call_reg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (link_we_o && opc_i == 6'd3) |-> link_idx_o == 5'd31);
endmodule

bind pc_sequencer pcseq_checker #(.TRAP_VECTOR(TRAP_VECTOR)) u_pcseq_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .pc_i          (pc_i),
    .opc_i         (instr_i[31:26]),
    .exc_illegal_i (exc_illegal_i),
    .exc_ovf_i     (exc_ovf_i),
    .exc_mem_i     (exc_mem_i),
    .next_pc_o     (next_pc_o),
    .link_we_o     (link_we_o),
    .link_idx_o    (link_idx_o),
    .epc_w         (epc_w),
    .cause_w       (cause_w)
);

// File: tb/test_pc_sequencer.sv
module test_pc_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] VEC = 32'h8000_0180;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc = '0, ins = '0, rs = '0, rt = '0;
    logic        e_ill = 1'b0, e_ovf = 1'b0, e_mem = 1'b0;
    logic [4:0]  sel = '0;
    logic [31:0] next_pc, link_val, rdata;
    logic        link_we;
    logic [4:0]  link_idx;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Reference state of the trap registers.
    logic [31:0] m_epc = '0;
    logic [3:0]  m_cause = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pc_sequencer i_pc_sequencer (
        .clk(clk), .rst_n(rst_n), .pc_i(pc), .instr_i(ins),
        .rs_val_i(rs), .rt_val_i(rt),
        .exc_illegal_i(e_ill), .exc_ovf_i(e_ovf), .exc_mem_i(e_mem),
        .cp0_sel_i(sel), .next_pc_o(next_pc), .link_we_o(link_we),
        .link_idx_o(link_idx), .link_val_o(link_val), .cp0_rdata_o(rdata)
    );

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic string flow_tag(logic [31:0] w, bit exc);
        int op = int'(w[31:26]);
        if (exc) return "R7";
        if (op == 4 || op == 5) return "R2";
        if (op == 1 || op == 6 || op == 7) return "R3";
        if (op == 2 || op == 3) return "R4";
        if (op == 0 && (w[5:0] == 8 || w[5:0] == 9)) return "R5";
        return "R1";
    endfunction

    function automatic logic [31:0] expect_next(logic [31:0] p, logic [31:0] w,
                                                logic [31:0] a, logic [31:0] b, bit exc);
        logic [31:0] s;
        logic [31:0] bt;
        int op;
        if (exc) return VEC;
        s  = p + 32'd4;
        bt = s + (32'($signed(w[15:0])) << 2);
        op = int'(w[31:26]);
        if (op == 2 || op == 3) return {p[31:28], w[25:0], 2'b00};
        if (op == 0 && (w[5:0] == 8 || w[5:0] == 9)) return a;
        if (op == 4) return (a == b) ? bt : s;
        if (op == 5) return (a != b) ? bt : s;
        if (op == 6) return ($signed(a) <= 0) ? bt : s;
        if (op == 7) return ($signed(a) > 0) ? bt : s;
        if (op == 1 && w[20:16] == 0) return ($signed(a) < 0) ? bt : s;
        return s;
    endfunction

    // One cycle: drive, compare mid-cycle, then advance the model at the edge.
    task automatic step(logic [31:0] p, logic [31:0] w, logic [31:0] a, logic [31:0] b,
                        logic [2:0] exc, logic [4:0] s);
        bit any;
        bit we_exp;
        logic [31:0] rd_exp;
        string rtag;
        pc = p; ins = w; rs = a; rt = b;
        e_ill = exc[2]; e_ovf = exc[1]; e_mem = exc[0]; sel = s;
        any = |exc;
        #(CLK_PERIOD/4);
        check(flow_tag(w, any), "next_pc", next_pc, expect_next(p, w, a, b, any));
        we_exp = (w[31:26] == 3) || (w[31:26] == 0 && w[5:0] == 9);
        check(any ? "R9" : "R6", "link_we", {31'd0, link_we}, {31'd0, we_exp && !any});
        if (we_exp && !any) begin
            check("R6", "link_idx", {27'd0, link_idx}, (w[31:26] == 3) ? 32'd31 : {27'd0, w[15:11]});
            check("R6", "link_val", link_val, p + 32'd4);
        end
        rd_exp = (s == 14) ? m_epc : (s == 13) ? {28'd0, m_cause} : 32'd0;
        rtag = (s == 13) ? "R8" : (s == 14) ? "R7" : "R10";
        check(rtag, "cp0_rdata", rdata, rd_exp);
        @(posedge clk);
        if (any) begin
            m_epc   = p;
            m_cause = exc[2] ? 4'd10 : exc[1] ? 4'd12 : 4'd4;
        end
        @(negedge clk);
    endtask

    function automatic logic [31:0] mk(int op, int rsf, int rtf, int low);
        return {6'(op), 5'(rsf), 5'(rtf), 16'(low)};
    endfunction

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        int ops[10] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 35};
        int fns[3]  = '{8, 9, 33};
        repeat (3) @(negedge clk);
        sel = 5'd14; #1;
        check("R10", "epc after reset", rdata, 32'd0);
        sel = 5'd13; #1;
        check("R10", "cause after reset", rdata, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 sequential
        step(32'h0000_0100, 32'h0000_0021, 1, 2, 3'b000, 5'd0);
        // R2 beq taken backwards, not taken; bne taken forward
        step(32'h0000_0200, mk(4, 1, 2, 16'hFFFF), 5, 5, 3'b000, 5'd0);
        step(32'h0000_0200, mk(4, 1, 2, 16'hFFFF), 5, 6, 3'b000, 5'd0);
        step(32'h0000_0200, mk(5, 1, 2, 16'h0010), 5, 6, 3'b000, 5'd0);
        // R3 signed zero compares, opcode 1 with nonzero rt is sequential
        step(32'h0000_0300, mk(6, 1, 0, 8), 0, 0, 3'b000, 5'd0);
        step(32'h0000_0300, mk(7, 1, 0, 8), 0, 0, 3'b000, 5'd0);
        step(32'h0000_0300, mk(7, 1, 0, 8), 32'h8000_0000, 0, 3'b000, 5'd0);
        step(32'h0000_0300, mk(1, 1, 0, 8), 32'h8000_0000, 0, 3'b000, 5'd0);
        step(32'h0000_0300, mk(1, 1, 1, 8), 32'h8000_0000, 0, 3'b000, 5'd0);
        // R4 jumps keep region bits
        step(32'hA000_0000, {6'd2, 26'h3FF_FFFF}, 0, 0, 3'b000, 5'd0);
        step(32'h5000_0010, {6'd3, 26'h000_0040}, 0, 0, 3'b000, 5'd0);
        // R5 register jumps, R6 register call into rd=7
        step(32'h0000_0400, {6'd0, 5'd3, 5'd0, 5'd0, 5'd0, 6'd8}, 32'h1234_5678, 0, 3'b000, 5'd0);
        step(32'h0000_0400, {6'd0, 5'd3, 5'd0, 5'd7, 5'd0, 6'd9}, 32'h0000_9000, 0, 3'b000, 5'd0);
        // R7/R9 call with exception, then read back address and cause
        step(32'h0000_0500, {6'd3, 26'h100}, 0, 0, 3'b010, 5'd0);
        step(32'h0000_0504, 32'h0000_0021, 0, 0, 3'b000, 5'd14);
        step(32'h0000_0508, 32'h0000_0021, 0, 0, 3'b000, 5'd13);
        // R8 priority combinations
        step(32'h0000_0600, mk(4, 1, 2, 3), 1, 1, 3'b111, 5'd0);
        step(32'h0000_0604, 32'h0000_0021, 0, 0, 3'b000, 5'd13);
        step(32'h0000_0700, 32'h0000_0021, 0, 0, 3'b011, 5'd0);
        step(32'h0000_0704, 32'h0000_0021, 0, 0, 3'b000, 5'd13);
        step(32'h0000_0800, 32'h0000_0021, 0, 0, 3'b001, 5'd13);
        step(32'h0000_0804, 32'h0000_0021, 0, 0, 3'b000, 5'd13);
        // R10 unmapped selector reads zero, registers held
        step(32'h0000_0900, 32'h0000_0021, 0, 0, 3'b000, 5'd12);
        step(32'h0000_0904, 32'h0000_0021, 0, 0, 3'b000, 5'd14);

        for (int n = 0; n < 800; n++) begin
            int op;
            logic [31:0] w, a, b;
            logic [2:0] e;
            logic [4:0] s;
            op = ops[$urandom_range(0, 9)];
            if (op == 8) w = {6'd0, 20'($urandom), 6'(fns[$urandom_range(0, 2)])};
            else w = {6'(op), 26'($urandom)};
            if ($urandom_range(0, 3) == 0) w[20:16] = 5'd0;
            a = $urandom;
            case ($urandom_range(0, 3))
                0: a = 32'd0;
                1: a = 32'h8000_0000 | a;
                default: ;
            endcase
            b = ($urandom_range(0, 2) == 0) ? a : 32'($urandom);
            e = ($urandom_range(0, 5) == 0) ? 3'($urandom_range(1, 7)) : 3'b000;
            case ($urandom_range(0, 2))
                0: s = 5'd13;
                1: s = 5'd14;
                default: s = 5'($urandom);
            endcase
            step(32'($urandom) & 32'hFFFF_FFFC, w, a, b, e, s);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule